// File: doc/BRIEF.md
# Regulator Status Poller and Fault Logger

This block watches an external voltage regulator through its one-byte summary status register. In host mode, with polling enabled, it starts a read-byte transaction on a simple request/acknowledge bus port at a fixed cadence. The cadence is nominally 500 ms and is set in clock cycles by a parameter. A zero status byte is healthy and is dropped. A nonzero byte is broken into its set bits. Each set bit becomes one record on a FIFO-style push port, and a sticky error pin goes high. A negative acknowledge or a silent bus is recorded as a single communication-fault record.

The status bits are numbered as follows:
- bit 0: any other fault
- bit 1: communication, memory or logic fault
- bit 2: temperature fault or warning
- bit 3: input under-voltage
- bit 4: output over-current
- bit 5: output over-voltage
- bit 6: output off
- bit 7: busy

When the block acts as a bus target it does not poll. Instead it raises an alert output while an error is pending, so that an external host can run its alert-response read. The host signals that the read is complete with a one-cycle pulse.

Top module: `reg_status_poller`

## Requirements
- R1: With `poll_en_i`=1 and `target_mode_i`=0, `rd_req_o` rises once every `POLL_CYCLES` clock cycles, as long as each read and split completes within the period. While `rd_req_o` is high, `rd_cmd_o` is 8'h78.
- R2: While `poll_en_i`=0 or `target_mode_i`=1, no read request is issued.
- R3: A read acknowledged with status byte 8'h00 pushes no record and leaves `err_o` unchanged.
- R4: A nonzero status byte pushes one record per set bit, one per clock, in order from the lowest set bit. `q_idx_o` carries the bit position. For example, 8'h06 gives index 1 and then index 2.
- R5: `q_seq_o` of the first record after reset is 0, and it rises by one with every record pushed.
- R6: No record is pushed while `q_full_i`=1. Records held back by a full queue are pushed later without loss or reordering.
- R7: A read that ends with `rd_nack_i`, or that gets no response for `TIMEOUT_CYCLES` cycles, pushes exactly one record with index 1.
- R8: `err_o` goes high on the clock edge where any fault is taken and stays high until a `clr_err_i` pulse. If a fault and a clear occur in the same cycle, `err_o` stays high.
- R9: `alert_o` equals `target_mode_i` AND a pending flag. The flag is set by any taken fault and cleared by `ara_done_i`. A fault taken in the same cycle as `ara_done_i` leaves the flag set.
- R10: While `rst_ni`=0, `rd_req_o`, `q_push_o`, `err_o` and `alert_o` are 0.
- R11: A poll that falls due while a read or split is still in progress is skipped. No request is made while records are still being pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_en_i | input | 1 | Enables periodic status polling |
| target_mode_i | input | 1 | 1: bus-target mode (no polling, alert enabled) |
| clr_err_i | input | 1 | Pulse that clears `err_o` |
| ara_done_i | input | 1 | Pulse: host finished the alert-response read |
| rd_req_o | output | 1 | Read-byte request, held until acknowledged or timed out |
| rd_cmd_o | output | 8 | Command code for the read |
| rd_ack_i | input | 1 | Read completed, `rd_data_i` valid |
| rd_nack_i | input | 1 | Read refused by the target |
| rd_data_i | input | 8 | Status byte returned |
| q_push_o | output | 1 | Pushes one record into the error queue |
| q_idx_o | output | 3 | Status bit index of the record |
| q_seq_o | output | SEQ_W | Sequence number of the record |
| q_full_i | input | 1 | Queue cannot accept a record |
| err_o | output | 1 | Sticky error pin |
| alert_o | output | 1 | Alert to an external bus host |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is a fault being taken and a clear of the error pin. The second pair is a fault being taken and the host's alert-response completion. The bench ties the clear or completion pulse to the acknowledge of a faulty read, so both strike the same edge. It then checks that the error pin stays high. It also checks that, after switching to target mode, the alert is still raised and falls only on a later completion pulse. A third overlap, a poll falling due during a queue-full stall, is provoked by holding the queue full for longer than one poll period. The bench judges it by the absence of any request until all eight records have drained in order.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int STAT_W = 8;
  localparam int IDX_W  = 3;
  localparam logic [7:0] CMD_STATUS = 8'h78;

  typedef enum logic [IDX_W-1:0] {
    ST_OTHER = 3'd0,
    ST_COMM  = 3'd1,
    ST_TEMP  = 3'd2,
    ST_VIN_UV = 3'd3,
    ST_IOUT_OC = 3'd4,
    ST_VOUT_OV = 3'd5,
    ST_OFF   = 3'd6,
    ST_BUSY  = 3'd7
  } stat_bit_e;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_WAIT = 1'b1
  } rd_state_e;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [STAT_W-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = STAT_W - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/rsp_poll_timer.sv
module rsp_poll_timer #(
  parameter int POLL_CYCLES = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsp_bus_reader.sv
module rsp_bus_reader
  import rsp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [7:0]        rd_cmd_o,
  input  logic              rd_ack_i,
  input  logic              rd_nack_i,
  input  logic [STAT_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              busy_o
);
  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYCLES - 1);
  localparam logic [STAT_W-1:0] COMM_MASK = STAT_W'(1) << ST_COMM;

  rd_state_e      state_q;
  logic [TO_W-1:0] to_cnt_q;
  logic           timed_out;

  assign timed_out = (to_cnt_q == TO_LAST);
  assign rd_req_o  = (state_q == RD_WAIT);
  assign rd_cmd_o  = CMD_STATUS;
  assign busy_o    = (state_q == RD_WAIT);
  assign done_o    = rd_req_o && (rd_ack_i || rd_nack_i || timed_out);
  // ack wins over nack; a failed read reports as one comm fault
  assign mask_o    = rd_ack_i ? rd_data_i : COMM_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RD_IDLE;
      to_cnt_q <= '0;
    end else begin
      unique case (state_q)
        RD_IDLE: begin
          to_cnt_q <= '0;
          if (start_i) state_q <= RD_WAIT;
        end
        RD_WAIT: begin
          if (done_o) begin
            state_q  <= RD_IDLE;
            to_cnt_q <= '0;
          end else begin
            to_cnt_q <= to_cnt_q + 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsp_fault_splitter.sv
module rsp_fault_splitter
  import rsp_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              q_full_i,
  output logic              push_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SEQ_W-1:0]  seq_o,
  output logic              busy_o
);
  logic [STAT_W-1:0] mask_q;
  logic [SEQ_W-1:0]  seq_q;

  assign busy_o = |mask_q;
  assign push_o = busy_o && !q_full_i;
  assign idx_o  = lowest_set(mask_q);
  assign seq_o  = seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      seq_q  <= '0;
    end else begin
      if (load_i) begin
        mask_q <= mask_i;
      end else if (push_o) begin
        mask_q <= mask_q & (mask_q - 1'b1);
      end
      if (push_o) seq_q <= seq_q + 1'b1;
    end
  end
endmodule

// File: rtl/reg_status_poller.sv
module reg_status_poller
  import rsp_pkg::*;
#(
  parameter int POLL_CYCLES    = 25_000_000,
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int SEQ_W          = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             poll_en_i,
  input  logic             target_mode_i,
  input  logic             clr_err_i,
  input  logic             ara_done_i,
  output logic             rd_req_o,
  output logic [7:0]       rd_cmd_o,
  input  logic             rd_ack_i,
  input  logic             rd_nack_i,
  input  logic [7:0]       rd_data_i,
  output logic             q_push_o,
  output logic [2:0]       q_idx_o,
  output logic [SEQ_W-1:0] q_seq_o,
  input  logic             q_full_i,
  output logic             err_o,
  output logic             alert_o
);
  logic run, tick, start;
  logic rd_busy, sp_busy;
  logic rd_done;
  logic [STAT_W-1:0] rd_mask;
  logic fault_take;
  logic err_q, pend_q;

  assign run        = poll_en_i && !target_mode_i;
  assign start      = tick && !rd_busy && !sp_busy;
  assign fault_take = rd_done && (|rd_mask);

  rsp_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  rsp_bus_reader #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_reader (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_req_o  (rd_req_o),
    .rd_cmd_o  (rd_cmd_o),
    .rd_ack_i  (rd_ack_i),
    .rd_nack_i (rd_nack_i),
    .rd_data_i (rd_data_i),
    .done_o    (rd_done),
    .mask_o    (rd_mask),
    .busy_o    (rd_busy)
  );

  rsp_fault_splitter #(.SEQ_W(SEQ_W)) u_split (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (fault_take),
    .mask_i   (rd_mask),
    .q_full_i (q_full_i),
    .push_o   (q_push_o),
    .idx_o    (q_idx_o),
    .seq_o    (q_seq_o),
    .busy_o   (sp_busy)
  );

  // set has priority over clear for both flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (fault_take)     err_q <= 1'b1;
      else if (clr_err_i) err_q <= 1'b0;
      if (fault_take)      pend_q <= 1'b1;
      else if (ara_done_i) pend_q <= 1'b0;
    end
  end

  assign err_o   = err_q;
  assign alert_o = target_mode_i && pend_q;
endmodule

// File: rtl/reg_status_poller_chk.sv
module reg_status_poller_chk #(
  parameter int SEQ_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             poll_en_i,
  input logic             target_mode_i,
  input logic             clr_err_i,
  input logic             ara_done_i,
  input logic             rd_req_o,
  input logic [7:0]       rd_cmd_o,
  input logic             q_push_o,
  input logic [SEQ_W-1:0] q_seq_o,
  input logic             q_full_i,
  input logic             err_o,
  input logic             alert_o
);
  assert_req_cmd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_cmd_o == 8'h78);

  assert_req_only_polling_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> $past(poll_en_i && !target_mode_i));

  assert_seq_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(q_push_o) |-> q_seq_o == SEQ_W'($past(q_seq_o) + 1'b1));

  assert_seq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(q_push_o) |-> $stable(q_seq_o));

  assert_no_push_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full_i |-> !q_push_o);

  assert_err_clear_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(clr_err_i));

  assert_alert_needs_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> target_mode_i);

  assert_alert_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(alert_o) && target_mode_i) |-> $past(ara_done_i || !target_mode_i));

  assert_no_req_while_split_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !q_push_o);
endmodule

bind reg_status_poller reg_status_poller_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .poll_en_i     (poll_en_i),
  .target_mode_i (target_mode_i),
  .clr_err_i     (clr_err_i),
  .ara_done_i    (ara_done_i),
  .rd_req_o      (rd_req_o),
  .rd_cmd_o      (rd_cmd_o),
  .q_push_o      (q_push_o),
  .q_seq_o       (q_seq_o),
  .q_full_i      (q_full_i),
  .err_o         (err_o),
  .alert_o       (alert_o)
);

// File: tb/reg_status_poller_bench.sv
`timescale 1ns/1ps
module reg_status_poller_bench;
  localparam int P     = 100;
  localparam int TO    = 16;
  localparam int SEQ_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_en = 1'b0, target = 1'b0;
  logic clr_man = 1'b0, ara_man = 1'b0;
  logic clr_on_ack = 1'b0, ara_on_ack = 1'b0;
  logic rd_ack = 1'b0, rd_nack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic q_full = 1'b0;
  logic clr_err, ara_done;
  logic rd_req, q_push, err, alert;
  logic [7:0] rd_cmd;
  logic [2:0] q_idx;
  logic [SEQ_W-1:0] q_seq;

  assign clr_err  = clr_man | (clr_on_ack & rd_ack);
  assign ara_done = ara_man | (ara_on_ack & rd_ack);

  always #10 clk = ~clk;

  reg_status_poller #(.POLL_CYCLES(P), .TIMEOUT_CYCLES(TO), .SEQ_W(SEQ_W)) u_reg_status_poller (
    .clk_i(clk), .rst_ni(rst_n), .poll_en_i(poll_en), .target_mode_i(target),
    .clr_err_i(clr_err), .ara_done_i(ara_done),
    .rd_req_o(rd_req), .rd_cmd_o(rd_cmd), .rd_ack_i(rd_ack), .rd_nack_i(rd_nack),
    .rd_data_i(rd_data), .q_push_o(q_push), .q_idx_o(q_idx), .q_seq_o(q_seq),
    .q_full_i(q_full), .err_o(err), .alert_o(alert)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int ent_n = 0, req_n = 0;
  logic [2:0] ent_idx [0:127];
  int ent_cyc [0:127];
  int req_cyc [0:63];
  logic prev_req = 1'b0;
  int resp_kind = 0;           // 0 ack, 1 nack, 2 silent
  logic [7:0] resp_data = 8'h00;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wait_req();
    int r0;
    r0 = req_n;
    while (req_n == r0) step(1);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // responder
  always begin
    @(posedge clk); #2;
    rd_ack  = 1'b0;
    rd_nack = 1'b0;
    if (rst_n && rd_req) begin
      if (resp_kind == 0) begin
        rd_ack  = 1'b1;
        rd_data = resp_data;
      end else if (resp_kind == 1) begin
        rd_nack = 1'b1;
      end
    end
  end

  // monitor, mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (q_push) begin
        chk(q_seq == SEQ_W'(ent_n), "R5 seq", int'(q_seq), ent_n);
        if (ent_n < 128) begin
          ent_idx[ent_n] = q_idx;
          ent_cyc[ent_n] = cyc;
        end
        ent_n++;
      end
      if (rd_req && !prev_req) begin
        chk(rd_cmd == 8'h78, "R1 cmd", int'(rd_cmd), 8'h78);
        if (req_n < 64) req_cyc[req_n] = cyc;
        req_n++;
      end
      prev_req = rd_req;
    end
  end

  task automatic t_reset();
    #5;
    chk(!rd_req, "R10 rd_req", int'(rd_req), 0);
    chk(!q_push, "R10 q_push", int'(q_push), 0);
    chk(!err, "R10 err", int'(err), 0);
    chk(!alert, "R10 alert", int'(alert), 0);
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic t_zero();
    int e0;
    e0 = ent_n;
    resp_kind = 0; resp_data = 8'h00;
    poll_en = 1'b1;
    wait_req();
    step(6);
    chk(ent_n == e0, "R3 no entry", ent_n - e0, 0);
    chk(!err, "R3 err unchanged", int'(err), 0);
  endtask

  task automatic t_two_bits();
    int e0;
    e0 = ent_n;
    resp_data = 8'h06;
    wait_req();
    step(6);
    chk(ent_n - e0 == 2, "R4 count 0x06", ent_n - e0, 2);
    chk(ent_idx[e0] == 3'd1, "R4 first idx", int'(ent_idx[e0]), 1);
    chk(ent_idx[e0+1] == 3'd2, "R4 second idx", int'(ent_idx[e0+1]), 2);
    chk(ent_cyc[e0+1] == ent_cyc[e0] + 1, "R4 one per clock",
        ent_cyc[e0+1] - ent_cyc[e0], 1);
    chk(err, "R8 err set", int'(err), 1);
  endtask

  task automatic t_zero_keeps_err_and_period();
    int e0;
    e0 = ent_n;
    resp_data = 8'h00;
    wait_req();
    wait_req();
    step(6);
    chk(ent_n == e0, "R3 zero no entry", ent_n - e0, 0);
    chk(err, "R3 err kept", int'(err), 1);
    chk(req_cyc[req_n-1] - req_cyc[req_n-2] == P, "R1 period",
        req_cyc[req_n-1] - req_cyc[req_n-2], P);
  endtask

  task automatic t_clear();
    clr_man = 1'b1; step(1); clr_man = 1'b0; step(1);
    chk(!err, "R8 cleared", int'(err), 0);
  endtask

  task automatic t_full_stall();
    int e0, r0;
    e0 = ent_n;
    q_full = 1'b1;
    resp_data = 8'hFF;
    wait_req();
    step(2);
    resp_data = 8'h00;
    r0 = req_n;
    step(150);
    chk(ent_n == e0, "R6 no push while full", ent_n - e0, 0);
    chk(req_n == r0, "R11 skipped poll", req_n - r0, 0);
    q_full = 1'b0;
    step(12);
    chk(ent_n - e0 == 8, "R6 all drained", ent_n - e0, 8);
    for (int i = 0; i < 8; i++)
      chk(ent_idx[e0+i] == 3'(i), "R4 ascending order", int'(ent_idx[e0+i]), i);
    chk(err, "R8 err after 0xFF", int'(err), 1);
  endtask

  task automatic t_nack();
    int e0;
    e0 = ent_n;
    resp_kind = 1;
    wait_req();
    step(4);
    resp_kind = 0;
    chk(ent_n - e0 == 1, "R7 nack one entry", ent_n - e0, 1);
    chk(ent_idx[e0] == 3'd1, "R7 nack idx", int'(ent_idx[e0]), 1);
  endtask

  task automatic t_timeout();
    int e0;
    t_clear();
    e0 = ent_n;
    resp_kind = 2;
    wait_req();
    step(TO - 3);
    chk(ent_n == e0, "R7 not before timeout", ent_n - e0, 0);
    step(6);
    resp_kind = 0;
    chk(ent_n - e0 == 1, "R7 timeout one entry", ent_n - e0, 1);
    chk(ent_idx[e0] == 3'd1, "R7 timeout idx", int'(ent_idx[e0]), 1);
    chk(err, "R8 err on timeout", int'(err), 1);
  endtask

  task automatic t_clear_collide();
    t_clear();
    resp_data = 8'h10;
    clr_on_ack = 1'b1;
    wait_req();
    step(3);
    clr_on_ack = 1'b0;
    resp_data = 8'h00;
    chk(err, "R8 set wins over clear", int'(err), 1);
  endtask

  task automatic t_disable();
    int r0;
    poll_en = 1'b0;
    r0 = req_n;
    step(3 * P + 20);
    chk(req_n == r0, "R2 disabled no req", req_n - r0, 0);
    poll_en = 1'b1;
  endtask

  task automatic t_target();
    int r0;
    chk(!alert, "R9 no alert in host mode", int'(alert), 0);
    target = 1'b1;
    step(1);
    chk(alert, "R9 alert pending", int'(alert), 1);
    r0 = req_n;
    step(3 * P + 20);
    chk(req_n == r0, "R2 target no req", req_n - r0, 0);
    ara_man = 1'b1; step(1); ara_man = 1'b0; step(1);
    chk(!alert, "R9 alert cleared", int'(alert), 0);
    // fault taken on the same edge as the completion pulse
    target = 1'b0;
    resp_data = 8'h01;
    ara_on_ack = 1'b1;
    wait_req();
    step(3);
    ara_on_ack = 1'b0;
    resp_data = 8'h00;
    target = 1'b1;
    step(1);
    chk(alert, "R9 fault wins over ara", int'(alert), 1);
    ara_man = 1'b1; step(1); ara_man = 1'b0; step(1);
    chk(!alert, "R9 alert cleared again", int'(alert), 0);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_two_bits();
    t_zero_keeps_err_and_period();
    t_clear();
    t_full_stall();
    t_nack();
    t_timeout();
    t_clear_collide();
    t_disable();
    t_target();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule